// File: doc/BRIEF.md
# Double-Precision Flag Comparator

This block compares two packed 64-bit binary floating-point values and reports the outcome as a four-bit condition code (negative, zero, carry, overflow) plus an invalid-operation flag. It is purely combinational: the result follows the operands in the same cycle. An execution pipeline reads the code to decide conditional moves and branches.

Ordered results come from integer comparison of the raw encodings. When the two signs differ, the negative value is the smaller one. When the signs match, the unsigned comparison of the encodings decides, and the sense is inverted when both values are negative. Both signed zeros compare equal. When either operand is a NaN the result is unordered. A NaN raises the invalid flag if it is signalling, and a quiet NaN raises it too when the signalling-compare control is set. A second control replaces the second operand with positive zero, which serves the compare-against-zero forms.

Top module: `fp64_cmp_flags`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 62:52) is all ones and its fraction (bits 51:0) is nonzero. Any NaN operand gives flags_o = 4'b0011, with flags_o[3]=N, [2]=Z, [1]=C and [0]=V, so that only C and V are set.
- R2: A NaN whose fraction bit 51 is clear is signalling. It sets invalid_o whatever the value of sig_qnan_i.
- R3: A NaN with fraction bit 51 set is quiet. It sets invalid_o only when sig_qnan_i is 1.
- R4: When neither operand is a NaN, invalid_o is 0 in both modes.
- R5: Identical non-NaN encodings give flags_o = 4'b0110 (Z and C).
- R6: +0 (64'h0) and -0 (64'h8000000000000000) compare equal in either order and give 4'b0110.
- R7: When the signs differ and the operands are not both zero, a negative first operand gives 4'b1000 (N, less than) and a positive one gives 4'b0010 (C, greater than).
- R8: For two positive operands, the operand with the larger unsigned encoding is the greater.
- R9: For two negative operands the ordering is reversed: the operand with the larger unsigned encoding is the smaller.
- R10: With zero_cmp_i = 1 the second operand is taken as 64'h0, and b_i has no effect on either output, even when b_i is a NaN.
- R11: Infinities (exponent all ones, fraction zero) are not NaNs. They are ordered as numbers, and two infinities of the same sign compare equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First operand, packed double |
| b_i | input | 64 | Second operand, packed double |
| sig_qnan_i | input | 1 | Quiet NaNs also raise invalid |
| zero_cmp_i | input | 1 | Replace the second operand with +0 |
| flags_o | output | 4 | Condition code {N,Z,C,V} |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
Directed cases cover the following:
- signalling and quiet NaNs in each operand position and in both modes, which separates the quiet-bit test from the mode test;
- the two signed zeros in either order;
- infinities against finite values;
- pairs of negative numbers, which expose a missing sense inversion;
- compare-with-zero with a NaN on b_i, which shows whether the substitution really masks the second input.

Random pairs bias the operand classes so that copies, sign flips and special values occur often. Each result is checked against a reference that orders values through a monotonic integer key, so the reference does not share the sign-split decision used by the design.

// File: rtl/fp64_cmp_pkg.sv
package fp64_cmp_pkg;
  typedef struct packed {
    logic sign;
    logic nan;
    logic quiet;
    logic mag_zero;
  } opnd_cls_t;

  // {N,Z,C,V}
  localparam logic [3:0] FL_LT = 4'b1000;
  localparam logic [3:0] FL_EQ = 4'b0110;
  localparam logic [3:0] FL_GT = 4'b0010;
  localparam logic [3:0] FL_UN = 4'b0011;
endpackage

// File: rtl/fp64_cmp_classify.sv
module fp64_cmp_classify
  import fp64_cmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  output opnd_cls_t             cls_o
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = op_i[W-2:FRAC_W];
  assign frac_f = op_i[FRAC_W-1:0];

  assign cls_o.sign     = op_i[W-1];
  assign cls_o.nan      = (&exp_f) && (|frac_f);
  assign cls_o.quiet    = frac_f[FRAC_W-1];
  assign cls_o.mag_zero = ~|op_i[W-2:0];
endmodule

// File: rtl/fp64_cmp_order.sv
module fp64_cmp_order
  import fp64_cmp_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  opnd_cls_t    a_cls_i,
  input  opnd_cls_t    b_cls_i,
  output logic [3:0]   flags_o
);
  logic a_below;

  // unsigned order of encodings, flipped when both are negative
  assign a_below = a_cls_i.sign ^ (a_i < b_i);

  always_comb begin
    if (a_cls_i.nan || b_cls_i.nan)                       flags_o = FL_UN;
    else if (a_i == b_i || (a_cls_i.mag_zero && b_cls_i.mag_zero)) flags_o = FL_EQ;
    else if (a_cls_i.sign != b_cls_i.sign)                flags_o = a_cls_i.sign ? FL_LT : FL_GT;
    else                                                  flags_o = a_below ? FL_LT : FL_GT;
  end
endmodule

// File: rtl/fp64_cmp_flags.sv
module fp64_cmp_flags
  import fp64_cmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  input  logic                  sig_qnan_i,
  input  logic                  zero_cmp_i,
  output logic [3:0]            flags_o,
  output logic                  invalid_o
);
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int N_OPND = 2;

  logic [W-1:0] opnd  [N_OPND];
  opnd_cls_t    cls   [N_OPND];
  logic [N_OPND-1:0] raise;

  assign opnd[0] = a_i;
  assign opnd[1] = zero_cmp_i ? '0 : b_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    fp64_cmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_i (opnd[g]),
      .cls_o(cls[g])
    );
    assign raise[g] = cls[g].nan && (sig_qnan_i || !cls[g].quiet);
  end

  assign invalid_o = |raise;

  fp64_cmp_order #(.W(W)) u_order (
    .a_i    (opnd[0]),
    .b_i    (opnd[1]),
    .a_cls_i(cls[0]),
    .b_cls_i(cls[1]),
    .flags_o(flags_o)
  );
endmodule

// File: rtl/fp64_cmp_flags_chk.sv
module fp64_cmp_flags_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic [EXP_W+FRAC_W:0] a_i,
  input logic [EXP_W+FRAC_W:0] b_i,
  input logic                  sig_qnan_i,
  input logic                  zero_cmp_i,
  input logic [3:0]            flags_o,
  input logic                  invalid_o
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [W-1:0] b_used;
  logic         a_nan, b_nan;

  assign b_used = zero_cmp_i ? '0 : b_i;
  assign a_nan  = (&a_i[W-2:FRAC_W]) && (|a_i[FRAC_W-1:0]);
  assign b_nan  = (&b_used[W-2:FRAC_W]) && (|b_used[FRAC_W-1:0]);

  always_comb begin
    // R1: only four legal codes, unordered exactly on NaN
    a_r1_legal_code: assert (flags_o == 4'b0011 || flags_o == 4'b0110 ||
                             flags_o == 4'b1000 || flags_o == 4'b0010);
    a_r1_unord_nan: assert ((flags_o == 4'b0011) == (a_nan || b_nan));
    // R4: invalid only with an unordered result
    a_r4_invalid_unord: assert (!invalid_o || flags_o == 4'b0011);
    // R3: signalling mode makes every unordered result invalid
    a_r3_sig_mode: assert (!(sig_qnan_i && flags_o == 4'b0011) || invalid_o);
    // R5: identical ordered operands are equal
    a_r5_same_eq: assert (!(a_i == b_used && !a_nan) || flags_o == 4'b0110);
    // R6: both magnitudes zero is equal
    a_r6_zero_eq: assert (!(a_i[W-2:0] == '0 && b_used[W-2:0] == '0) || flags_o == 4'b0110);
  end
endmodule

bind fp64_cmp_flags fp64_cmp_flags_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/fp64_cmp_flags_test.sv
module fp64_cmp_flags_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a, b;
  logic        sq, zc;
  logic [3:0]  flags;
  logic        inv;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  fp64_cmp_flags uut (
    .a_i(a), .b_i(b), .sig_qnan_i(sq), .zero_cmp_i(zc),
    .flags_o(flags), .invalid_o(inv)
  );

  function automatic bit is_nan(logic [63:0] x);
    return (x[62:52] == 11'h7ff) && (x[51:0] != 0);
  endfunction

  // monotonic key: smaller value -> smaller key
  function automatic logic [63:0] key(logic [63:0] x);
    return x[63] ? ~x : {1'b1, x[62:0]};
  endfunction

  function automatic logic [4:0] ref_cmp(logic [63:0] x, logic [63:0] y, logic s, logic z);
    logic [63:0] yy;
    logic        iv;
    yy = z ? 64'h0 : y;
    if (is_nan(x) || is_nan(yy)) begin
      iv = (is_nan(x) && (s || !x[51])) || (is_nan(yy) && (s || !yy[51]));
      return {4'b0011, iv};
    end
    if (x[62:0] == 0 && yy[62:0] == 0) return {4'b0110, 1'b0};
    if (key(x) < key(yy))  return {4'b1000, 1'b0};
    if (key(x) == key(yy)) return {4'b0110, 1'b0};
    return {4'b0010, 1'b0};
  endfunction

  task automatic apply(logic [63:0] x, logic [63:0] y, logic s, logic z, string req);
    logic [4:0] exp_v;
    @(negedge clk);
    a = x; b = y; sq = s; zc = z;
    #1;
    exp_v = ref_cmp(x, y, s, z);
    n_chk++;
    if ({flags, inv} !== exp_v) begin
      n_err++;
      $display("FAIL %s: a=%h b=%h sq=%0b zc=%0b got flags=%b inv=%b exp flags=%b inv=%b",
               req, x, y, s, z, flags, inv, exp_v[4:1], exp_v[0]);
    end
  endtask

  function automatic logic [63:0] rand_op();
    int unsigned sel;
    logic [63:0] r;
    sel = $urandom % 8;
    r = {$urandom, $urandom};
    case (sel)
      0: r = {r[63], 63'h0};
      1: r = {r[63], 11'h7ff, 52'h0};
      2: r = {r[63], 11'h7ff, 1'b1, r[50:0]};
      3: r = {r[63], 11'h7ff, 1'b0, r[50:1], 1'b1};
      4: r = {r[63], 11'h3ff, r[51:0]};
      default: ;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [63:0] x, logic [63:0] y, logic z);
    logic [63:0] yy;
    yy = z ? 64'h0 : y;
    if (z) return "R10";
    if (is_nan(x) || is_nan(yy)) return "R1";
    if (x == yy) return "R5";
    if (x[63] != yy[63]) return "R7";
    if (x[63]) return "R9";
    return "R8";
  endfunction

  localparam logic [63:0] P1 = 64'h3ff0000000000000, P2 = 64'h4000000000000000;
  localparam logic [63:0] N1 = 64'hbff0000000000000, N2 = 64'hc000000000000000;
  localparam logic [63:0] PINF = 64'h7ff0000000000000, NINF = 64'hfff0000000000000;
  localparam logic [63:0] QNAN = 64'h7ff8000000000000, SNAN = 64'h7ff0000000000001;
  localparam logic [63:0] NZ = 64'h8000000000000000;

  initial begin
    a = '0; b = '0; sq = 1'b0; zc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset/idle state: zeros equal
    apply(64'h0, 64'h0, 1'b0, 1'b0, "R5");
    apply(QNAN, P1, 1'b0, 1'b0, "R1");
    apply(P1, QNAN, 1'b0, 1'b0, "R1");
    apply(QNAN, P1, 1'b0, 1'b0, "R3");
    apply(P1, QNAN, 1'b1, 1'b0, "R3");
    apply(SNAN, P1, 1'b0, 1'b0, "R2");
    apply(P1, SNAN, 1'b0, 1'b0, "R2");
    apply(SNAN, QNAN, 1'b1, 1'b0, "R2");
    apply(P1, P2, 1'b1, 1'b0, "R4");
    apply(P2, P2, 1'b0, 1'b0, "R5");
    apply(64'h0, NZ, 1'b0, 1'b0, "R6");
    apply(NZ, 64'h0, 1'b1, 1'b0, "R6");
    apply(N1, P1, 1'b0, 1'b0, "R7");
    apply(P1, N2, 1'b0, 1'b0, "R7");
    apply(NZ, P1, 1'b0, 1'b0, "R7");
    apply(P1, P2, 1'b0, 1'b0, "R8");
    apply(P2, P1, 1'b0, 1'b0, "R8");
    apply(N1, N2, 1'b0, 1'b0, "R9");
    apply(N2, N1, 1'b0, 1'b0, "R9");
    apply(N1, P2, 1'b0, 1'b1, "R10");
    apply(P1, SNAN, 1'b1, 1'b1, "R10");
    apply(NZ, QNAN, 1'b1, 1'b1, "R10");
    apply(PINF, P2, 1'b0, 1'b0, "R11");
    apply(NINF, N2, 1'b0, 1'b0, "R11");
    apply(PINF, PINF, 1'b1, 1'b0, "R11");
    apply(NINF, PINF, 1'b0, 1'b0, "R11");

    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] x, y;
      int unsigned pick;
      logic s, z;
      x = rand_op();
      pick = $urandom % 10;
      if (pick < 3)      y = x;
      else if (pick < 4) y = {~x[63], x[62:0]};
      else               y = rand_op();
      s = $urandom % 2;
      z = ($urandom % 8) == 0;
      apply(x, y, s, z, tag_of(x, y, z));
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule